// File: doc/BRIEF.md
# Conditional Branch Evaluator

This block decides whether a short conditional branch should be taken and works out where it lands. Each request carries a four-bit condition selector from a sixteen-entry branch group, a signed eight-bit displacement and the address of the following instruction. The block tests the selected condition against the processor status flags (link/carry, fault, zero, minus), the interrupt-enable and clock-enable states, and four external sense switches. The sense switches are brought into the clock domain through a two-flop synchronizer before they are tested.

Requests arrive on a valid/ready stream, and results leave on another. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. The status levels present on that edge are sampled, and one cycle later the decision and the target appear with `out_valid` high. The result stays on the outputs, unchanged, until the consumer raises `out_ready`. While a result is held and `out_ready` is low, `in_ready` is low, so back-pressure passes straight through to the producer. The status and switch pins are plain levels and have no handshake.

Top module: `branch_cond_eval`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: Selector 0 is taken when link/carry is 1. Selector 1 is taken when link/carry is 0.
- R3: Selector 2 is taken when fault is 1. Selector 3 is taken when fault is 0.
- R4: Selector 4 is taken when zero is 1. Selector 5 is taken when zero is 0.
- R5: Selector 6 is taken when minus is 1. Selector 7 is taken when minus is 0, including when zero is 1.
- R6: Selector 8 is taken only when minus and zero are both 0. Selector 9 is taken in exactly the other cases.
- R7: Selectors 10, 11, 12 and 13 test `sense_sw[0]`, `[1]`, `[2]` and `[3]` respectively. A switch change that is settled before clock edge k does not affect requests accepted at edges k or k+1. It does affect requests accepted at edge k+2 and later.
- R8: Selector 14 is taken when `int_enabled` is 1. Selector 15 is taken when `clk_enabled` is 1.
- R9: `out_target` equals `in_next_pc` plus the sign-extended `in_disp`, modulo 2^16, whether or not the branch is taken.
- R10: After an accepting edge, `out_valid` is 1 on the next cycle. While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_taken` and `out_target` hold. When `out_ready` is 1, a new request can be accepted on the same edge that the old result is consumed.
- R11: The decision uses the status levels at the accepting edge. Later status changes do not alter a result that is already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| in_cond | input | 4 | Condition selector (0 to 15) |
| in_disp | input | 8 | Signed displacement |
| in_next_pc | input | 16 | Address of the next instruction |
| st_carry | input | 1 | Link/carry flag |
| st_fault | input | 1 | Fault flag |
| st_zero | input | 1 | Zero flag |
| st_minus | input | 1 | Minus flag |
| sense_sw | input | 4 | Asynchronous sense switch inputs |
| int_enabled | input | 1 | Interrupts enabled |
| clk_enabled | input | 1 | Real-time clock enabled |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_taken | output | 1 | Branch taken |
| out_target | output | 16 | Branch target address |

## Verification
The hardest case to reach from the ports is the two-cycle window after a sense switch changes. To hit it, the bench must issue requests on exactly the edges where the synchronizer still holds the old level. The directed test changes a switch in the same half-cycle that it presents a request, then keeps issuing back-to-back requests on that selector, and expects not-taken, not-taken, then taken. A second hard case is a held result while the status flags move. The bench holds `out_ready` low, flips the flags and queues a second request, and then checks that nothing changes until the result is released.

// File: rtl/bce_pkg.sv
package bce_pkg;

  typedef enum logic [3:0] {
    COND_CARRY   = 4'd0,
    COND_NCARRY  = 4'd1,
    COND_FAULT   = 4'd2,
    COND_NFAULT  = 4'd3,
    COND_ZERO    = 4'd4,
    COND_NZERO   = 4'd5,
    COND_MINUS   = 4'd6,
    COND_PLUS    = 4'd7,
    COND_GT      = 4'd8,
    COND_LE      = 4'd9,
    COND_SW1     = 4'd10,
    COND_SW2     = 4'd11,
    COND_SW3     = 4'd12,
    COND_SW4     = 4'd13,
    COND_INTEN   = 4'd14,
    COND_CLKEN   = 4'd15
  } cond_e;

  typedef struct packed {
    logic carry;
    logic fault;
    logic zero;
    logic minus;
  } status_t;

  localparam int unsigned SW_BASE = 10;

endpackage

// File: rtl/bce_sense_sync.sv
module bce_sense_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
        // R7: each stage carries the previous stage one cycle later
        p_sync_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
          rst_n && $past(rst_n) |-> stage_q[s] == $past(stage_q[s-1]));
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/bce_cond_select.sv
module bce_cond_select
  import bce_pkg::*;
#(
  parameter int unsigned NUM_SW = 4
) (
  input  logic [3:0]        code,
  input  status_t           st,
  input  logic [NUM_SW-1:0] sw,
  input  logic              int_en,
  input  logic              clk_en,
  output logic              taken
);

  localparam int unsigned NUM_COND = 16;

  logic [NUM_COND-1:0] cond_vec;
  logic                gt_zero;

  assign gt_zero = ~st.minus & ~st.zero;

  always_comb begin
    cond_vec = '0;
    cond_vec[COND_CARRY]  = st.carry;
    cond_vec[COND_NCARRY] = ~st.carry;
    cond_vec[COND_FAULT]  = st.fault;
    cond_vec[COND_NFAULT] = ~st.fault;
    cond_vec[COND_ZERO]   = st.zero;
    cond_vec[COND_NZERO]  = ~st.zero;
    cond_vec[COND_MINUS]  = st.minus;
    cond_vec[COND_PLUS]   = ~st.minus;
    cond_vec[COND_GT]     = gt_zero;
    cond_vec[COND_LE]     = ~gt_zero;
    cond_vec[COND_INTEN]  = int_en;
    cond_vec[COND_CLKEN]  = clk_en;
    for (int i = 0; i < NUM_SW; i++) begin
      cond_vec[SW_BASE + i] = sw[i];
    end
  end

  assign taken = cond_vec[code];

endmodule

// File: rtl/bce_target_calc.sv
module bce_target_calc #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DISP_W = 8
) (
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] target
);

  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;

  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign target   = next_pc + disp_ext;

endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import bce_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DISP_W      = 8,
  parameter int unsigned NUM_SW      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_cond,
  input  logic [DISP_W-1:0] in_disp,
  input  logic [ADDR_W-1:0] in_next_pc,
  input  logic              st_carry,
  input  logic              st_fault,
  input  logic              st_zero,
  input  logic              st_minus,
  input  logic [NUM_SW-1:0] sense_sw,
  input  logic              int_enabled,
  input  logic              clk_enabled,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_taken,
  output logic [ADDR_W-1:0] out_target
);

  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  status_t           status;
  logic [NUM_SW-1:0] sw_sync;
  logic              taken_d;
  logic [ADDR_W-1:0] target_d;
  logic              in_fire;

  assign status   = '{carry: st_carry, fault: st_fault, zero: st_zero, minus: st_minus};
  assign in_ready = ~out_valid | out_ready;
  assign in_fire  = in_valid & in_ready;

  bce_sense_sync #(.WIDTH(NUM_SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (sense_sw),
    .sync_out (sw_sync)
  );

  bce_cond_select #(.NUM_SW(NUM_SW)) u_cond (
    .code   (in_cond),
    .st     (status),
    .sw     (sw_sync),
    .int_en (int_enabled),
    .clk_en (clk_enabled),
    .taken  (taken_d)
  );

  bce_target_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
    .next_pc (in_next_pc),
    .disp    (in_disp),
    .target  (target_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_taken  <= 1'b0;
      out_target <= '0;
    end else begin
      if (in_fire) begin
        out_valid  <= 1'b1;
        out_taken  <= taken_d;
        out_target <= target_d;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end

  // R1: reset leaves the output side empty
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  // R10: accepted request yields a result next cycle
  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid);

  // R10: a stalled result holds and blocks input
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_taken) && $stable(out_target));

  p_stall_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R9: target is next address plus sign-extended displacement
  p_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_target == $past(in_next_pc + {{EXT_W{in_disp[DISP_W-1]}}, in_disp}));

  // R6: greater-than tests both minus and zero clear
  p_gt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_cond == COND_GT |=> out_taken == $past(!st_minus && !st_zero));

  // R5: zero result counts as positive
  p_plus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_cond == COND_PLUS && st_zero |=> out_taken == $past(!st_minus));

endmodule

// File: tb/branch_cond_eval_tb.sv
module branch_cond_eval_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [3:0]  in_cond;
  logic [7:0]  in_disp;
  logic [15:0] in_next_pc;
  logic        st_carry, st_fault, st_zero, st_minus;
  logic [3:0]  sense_sw;
  logic        int_enabled, clk_enabled;
  logic        out_valid, out_ready, out_taken;
  logic [15:0] out_target;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  branch_cond_eval dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cond(in_cond), .in_disp(in_disp), .in_next_pc(in_next_pc),
    .st_carry(st_carry), .st_fault(st_fault), .st_zero(st_zero), .st_minus(st_minus),
    .sense_sw(sense_sw), .int_enabled(int_enabled), .clk_enabled(clk_enabled),
    .out_valid(out_valid), .out_ready(out_ready), .out_taken(out_taken),
    .out_target(out_target)
  );

  typedef struct packed {
    logic [3:0]  code;
    logic        c, f, z, m;
    logic [3:0]  sw;
    logic        ie, ce;
    logic [7:0]  disp;
    logic [15:0] pc;
    logic        exp_taken;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  1'b1,1'b0,1'b0,1'b0, 4'h0, 1'b0,1'b0, 8'h05, 16'h1000, 1'b1, 4'd2}, // R2
    '{4'd0,  1'b0,1'b1,1'b1,1'b1, 4'hF, 1'b1,1'b1, 8'hFB, 16'h1000, 1'b0, 4'd2}, // R2
    '{4'd1,  1'b0,1'b0,1'b0,1'b0, 4'h0, 1'b0,1'b0, 8'h80, 16'h0010, 1'b1, 4'd2}, // R2 wrap
    '{4'd2,  1'b0,1'b1,1'b0,1'b0, 4'h0, 1'b0,1'b0, 8'h7F, 16'hFFF0, 1'b1, 4'd3}, // R3
    '{4'd3,  1'b1,1'b1,1'b0,1'b0, 4'h0, 1'b0,1'b0, 8'h00, 16'h2345, 1'b0, 4'd3}, // R3
    '{4'd4,  1'b0,1'b0,1'b1,1'b0, 4'h0, 1'b0,1'b0, 8'hFF, 16'h0000, 1'b1, 4'd4}, // R4
    '{4'd5,  1'b0,1'b0,1'b1,1'b0, 4'h0, 1'b0,1'b0, 8'h10, 16'h8000, 1'b0, 4'd4}, // R4
    '{4'd6,  1'b0,1'b0,1'b0,1'b1, 4'h0, 1'b0,1'b0, 8'h20, 16'h0100, 1'b1, 4'd5}, // R5
    '{4'd7,  1'b0,1'b0,1'b1,1'b0, 4'h0, 1'b0,1'b0, 8'hE0, 16'h0100, 1'b1, 4'd5}, // R5 zero is positive
    '{4'd7,  1'b0,1'b0,1'b0,1'b1, 4'h0, 1'b0,1'b0, 8'h01, 16'h0100, 1'b0, 4'd5}, // R5
    '{4'd8,  1'b1,1'b1,1'b0,1'b0, 4'h0, 1'b0,1'b0, 8'h02, 16'h4000, 1'b1, 4'd6}, // R6
    '{4'd8,  1'b0,1'b0,1'b1,1'b0, 4'h0, 1'b0,1'b0, 8'h02, 16'h4000, 1'b0, 4'd6}, // R6
    '{4'd9,  1'b0,1'b0,1'b1,1'b0, 4'h0, 1'b0,1'b0, 8'h03, 16'h4000, 1'b1, 4'd6}, // R6
    '{4'd9,  1'b0,1'b0,1'b0,1'b0, 4'h0, 1'b0,1'b0, 8'h03, 16'h4000, 1'b0, 4'd6}, // R6
    '{4'd10, 1'b0,1'b0,1'b0,1'b0, 4'h1, 1'b0,1'b0, 8'h04, 16'h0200, 1'b1, 4'd7}, // R7
    '{4'd11, 1'b0,1'b0,1'b0,1'b0, 4'h1, 1'b0,1'b0, 8'h04, 16'h0200, 1'b0, 4'd7}, // R7
    '{4'd12, 1'b0,1'b0,1'b0,1'b0, 4'h4, 1'b0,1'b0, 8'h04, 16'h0200, 1'b1, 4'd7}, // R7
    '{4'd13, 1'b0,1'b0,1'b0,1'b0, 4'h8, 1'b0,1'b0, 8'h04, 16'h0200, 1'b1, 4'd7}, // R7
    '{4'd13, 1'b1,1'b1,1'b1,1'b1, 4'h7, 1'b1,1'b1, 8'h04, 16'h0200, 1'b0, 4'd7}, // R7
    '{4'd14, 1'b0,1'b0,1'b0,1'b0, 4'h0, 1'b1,1'b0, 8'hC0, 16'h0030, 1'b1, 4'd8}, // R8
    '{4'd15, 1'b0,1'b0,1'b0,1'b0, 4'h0, 1'b0,1'b1, 8'h40, 16'hFFE0, 1'b1, 4'd8}, // R8
    '{4'd15, 1'b0,1'b0,1'b0,1'b0, 4'h0, 1'b1,1'b0, 8'h40, 16'hFFE0, 1'b0, 4'd8}  // R8
  };

  function automatic logic [15:0] exp_tgt(input logic [15:0] pc, input logic [7:0] d);
    return pc + {{8{d[7]}}, d};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_status(input logic c, f, z, m, input logic [3:0] sw, input logic ie, ce);
    st_carry = c; st_fault = f; st_zero = z; st_minus = m;
    sense_sw = sw; int_enabled = ie; clk_enabled = ce;
  endtask

  // called at a negedge with out_ready high; returns at the negedge after acceptance
  task automatic issue(input logic [3:0] code, input logic [7:0] d, input logic [15:0] pc);
    in_cond = code; in_disp = d; in_next_pc = pc; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_cond = '0; in_disp = '0; in_next_pc = '0;
    set_status(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R1 in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R1 in_ready after reset", {31'd0, in_ready}, 32'd1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      set_status(VECS[i].c, VECS[i].f, VECS[i].z, VECS[i].m, VECS[i].sw, VECS[i].ie, VECS[i].ce);
      repeat (3) @(negedge clk);
      issue(VECS[i].code, VECS[i].disp, VECS[i].pc);
      chk($sformatf("R%0d vec %0d taken", VECS[i].req, i), {31'd0, out_taken}, {31'd0, VECS[i].exp_taken});
      chk($sformatf("R9 vec %0d target", i), {16'd0, out_target}, {16'd0, exp_tgt(VECS[i].pc, VECS[i].disp)});
      chk($sformatf("R10 vec %0d valid", i), {31'd0, out_valid}, 32'd1);
    end
    @(negedge clk);
    chk("R10 valid drops when consumed", {31'd0, out_valid}, 32'd0);

    // R7 synchronizer latency: switch 2 rises with the first request
    set_status(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    sense_sw = 4'h2;
    issue(4'd11, 8'h00, 16'h0050);
    chk("R7 edge k", {31'd0, out_taken}, 32'd0);
    issue(4'd11, 8'h00, 16'h0050);
    chk("R7 edge k+1", {31'd0, out_taken}, 32'd0);
    issue(4'd11, 8'h00, 16'h0050);
    chk("R7 edge k+2", {31'd0, out_taken}, 32'd1);

    // R10 / R11 back-pressure with status moving
    set_status(1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    out_ready = 1'b0;
    issue(4'd0, 8'h08, 16'h0700);
    chk("R10 held valid", {31'd0, out_valid}, 32'd1);
    chk("R10 in_ready low while stalled", {31'd0, in_ready}, 32'd0);
    st_carry = 1'b0;
    in_cond = 4'd1; in_disp = 8'hF8; in_next_pc = 16'h0900; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 taken held after status change", {31'd0, out_taken}, 32'd1);
    chk("R10 target held", {16'd0, out_target}, {16'd0, exp_tgt(16'h0700, 8'h08)});
    chk("R10 in_ready still low", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 queued request taken", {31'd0, out_taken}, 32'd1);
    chk("R10 queued request target", {16'd0, out_target}, {16'd0, exp_tgt(16'h0900, 8'hF8)});
    chk("R10 queued request valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    chk("R10 drained", {31'd0, out_valid}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule